// File: doc/BRIEF.md
# Parallel prefix carry adder

A purely combinational N-bit adder (32 bits by default) that adds two operands and a carry-in and returns the N-bit sum and the carry-out. Each column first forms a generate bit (both operand bits set) and a propagate bit (either operand bit set). The carry-in is treated as an extra column below bit 0, whose generate is the carry-in and whose propagate is zero. A tree of prefix cells then merges adjacent spans of doubling width (1, 2, 4, ... columns). After log2(N) levels, every column knows the group generate from the column just below it down to the carry-in column, and that value is its carry.

Each sum bit is the XOR of the two operand bits and the carry into that column. The carry-out is formed by one final merge of the top column with the carry into that column. The width N is a parameter and must be a power of two, at least 2. The tree is built entirely by generate loops, so its depth grows with log2(N) rather than with N.

Top module: `prefix_adder`

## Requirements
- R1: `sum_o` equals the low N bits of `a_i + b_i + ci_i`, with the operands read as unsigned numbers, for every input combination.
- R2: `co_o` equals bit N (the bit just above the sum) of the full-width result `a_i + b_i + ci_i`.
- R3: When bit N-1 of both operands is 1, `co_o` is 1 whatever the other bits and `ci_i` are.
- R4: When bit N-1 of both operands is 0, `co_o` is 0 whatever the other bits and `ci_i` are.
- R5: When `a_i ^ b_i` is all ones, every column propagates. `co_o` then equals `ci_i`, and every bit of `sum_o` equals `~ci_i`.
- R6: With both operands zero, `sum_o` equals `ci_i` placed in bit 0 and `co_o` is 0.
- R7: With both operands all ones, `co_o` is 1, bits N-1..1 of `sum_o` are 1, and bit 0 of `sum_o` equals `ci_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| ci_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| co_o | output | 1 | Carry out of bit N-1 |

## Verification
The block holds no state. A wrong prefix cell or a misplaced span link therefore shows at once, in the same evaluation, as a wrong sum bit at or above the column whose carry it feeds. It can also show as a wrong carry-out. A fault often shows only for operand patterns in which that particular span both propagates and receives a carry from below. For that reason, a 4-bit instance is swept over every operand and carry-in combination. The 32-bit instance gets random vectors plus the long propagate chains (complementary operands, all ones, one plus all ones), which exercise the deepest spans of the tree.

// File: rtl/prefix_adder_pkg.sv
package prefix_adder_pkg;

  // Offset of level lvl inside the packed triangular propagate store.
  // Level l holds propagate bits only for tree indices >= 2**l.
  function automatic int p_base(input int lvl, input int n);
    return lvl * n - ((1 << lvl) - 1);
  endfunction

endpackage

// File: rtl/pfx_pg_col.sv
module pfx_pg_col #(
  parameter int N = 32
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] g_o,
  output logic [N-1:0] p_o,
  output logic [N-1:0] x_o
);

  for (genvar i = 0; i < N; i++) begin : g_col
    assign g_o[i] = a_i[i] & b_i[i];
    assign p_o[i] = a_i[i] | b_i[i];
    assign x_o[i] = a_i[i] ^ b_i[i];
  end

endmodule

// File: rtl/pfx_black.sv
module pfx_black (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  input  logic p_lo_i,
  output logic g_o,
  output logic p_o
);

  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
  assign p_o = p_hi_i & p_lo_i;

endmodule

// File: rtl/pfx_gray.sv
// Merge whose lower span already reaches the carry-in column: no propagate out.
module pfx_gray (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  output logic g_o
);

  assign g_o = g_hi_i | (p_hi_i & g_lo_i);

endmodule

// File: rtl/pfx_tree.sv
// Tree index j stands for column j-1; index 0 is the carry-in column.
module pfx_tree #(
  parameter int N = 32
) (
  input  logic         ci_i,
  input  logic [N-2:0] g_col_i,
  input  logic [N-2:0] p_col_i,
  output logic [N-1:0] carry_o
);

  localparam int LVLS  = $clog2(N);
  localparam int PBITS = prefix_adder_pkg::p_base(LVLS, N);

  wire [N-1:0]     g_st [LVLS+1];
  wire [PBITS-1:0] p_st;

  assign g_st[0]      = {g_col_i, ci_i};
  assign p_st[N-2:0]  = p_col_i;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int D      = 1 << l;
    localparam int PB_IN  = prefix_adder_pkg::p_base(l, N);
    localparam int PB_OUT = prefix_adder_pkg::p_base(l + 1, N);

    for (genvar j = 0; j < N; j++) begin : g_idx
      if (j < D) begin : g_pass
        assign g_st[l+1][j] = g_st[l][j];
      end else if (j < 2 * D) begin : g_gry
        pfx_gray i_gray (
          .g_hi_i (g_st[l][j]),
          .p_hi_i (p_st[PB_IN + j - D]),
          .g_lo_i (g_st[l][j-D]),
          .g_o    (g_st[l+1][j])
        );
      end else begin : g_blk
        pfx_black i_black (
          .g_hi_i (g_st[l][j]),
          .p_hi_i (p_st[PB_IN + j - D]),
          .g_lo_i (g_st[l][j-D]),
          .p_lo_i (p_st[PB_IN + j - 2 * D]),
          .g_o    (g_st[l+1][j]),
          .p_o    (p_st[PB_OUT + j - 2 * D])
        );
      end
    end
  end

  assign carry_o = g_st[LVLS];

endmodule

// File: rtl/prefix_adder.sv
module prefix_adder #(
  parameter int N = 32
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         ci_i,
  output logic [N-1:0] sum_o,
  output logic         co_o
);

  logic [N-1:0] g_col, p_col, x_col;
  logic [N-1:0] carry;

  pfx_pg_col #(.N(N)) i_pg (
    .a_i (a_i),
    .b_i (b_i),
    .g_o (g_col),
    .p_o (p_col),
    .x_o (x_col)
  );

  pfx_tree #(.N(N)) i_tree (
    .ci_i    (ci_i),
    .g_col_i (g_col[N-2:0]),
    .p_col_i (p_col[N-2:0]),
    .carry_o (carry)
  );

  // top column folded with its incoming carry gives the carry-out
  pfx_gray i_cout (
    .g_hi_i (g_col[N-1]),
    .p_hi_i (p_col[N-1]),
    .g_lo_i (carry[N-1]),
    .g_o    (co_o)
  );

  assign sum_o = x_col ^ carry;

endmodule

// File: rtl/prefix_adder_chk.sv
module prefix_adder_chk #(
  parameter int N = 32
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         ci_i,
  input logic [N-1:0] sum_o,
  input logic         co_o
);

  logic [N:0] ref_full;
  logic       known;

  always_comb begin
    ref_full = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, ci_i};
    known    = !$isunknown({a_i, b_i, ci_i, sum_o, co_o});
  end

  always_comb begin
    if (known) begin
      AST_SUM_EXACT: assert (sum_o == ref_full[N-1:0]); // R1
      AST_CARRY_EXACT: assert (co_o == ref_full[N]); // R2
      if (a_i[N-1] && b_i[N-1])
        AST_TOP_GEN: assert (co_o); // R3
      if (!a_i[N-1] && !b_i[N-1])
        AST_TOP_KILL: assert (!co_o); // R4
      if ((a_i ^ b_i) == '1)
        AST_FULL_PROP: assert (co_o == ci_i && sum_o == {N{~ci_i}}); // R5
      if (a_i == '0 && b_i == '0)
        AST_ZERO_OPS: assert (!co_o && sum_o == {{(N-1){1'b0}}, ci_i}); // R6
      if (a_i == '1 && b_i == '1)
        AST_ALL_ONES: assert (co_o && sum_o == {{(N-1){1'b1}}, ci_i}); // R7
    end
  end

endmodule

bind prefix_adder prefix_adder_chk #(.N(N)) i_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .ci_i  (ci_i),
  .sum_o (sum_o),
  .co_o  (co_o)
);

// File: tb/test_prefix_adder.sv
`timescale 1ns/1ps
module test_prefix_adder;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] a32 = '0, b32 = '0;
  logic        c32 = 1'b0;
  logic [31:0] s32;
  logic        co32;

  logic [3:0]  a4 = '0, b4 = '0;
  logic        c4 = 1'b0;
  logic [3:0]  s4;
  logic        co4;

  prefix_adder #(.N(32)) i_prefix_adder (
    .a_i (a32), .b_i (b32), .ci_i (c32), .sum_o (s32), .co_o (co32)
  );

  prefix_adder #(.N(4)) i_prefix_adder_w4 (
    .a_i (a4), .b_i (b4), .ci_i (c4), .sum_o (s4), .co_o (co4)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic c);
    @(posedge clk);
    a32 = a; b32 = b; c32 = c;
    @(negedge clk);
  endtask

  task automatic arith32(input string tag);
    logic [32:0] e;
    e = {1'b0, a32} + {1'b0, b32} + {32'd0, c32};
    chk(s32 == e[31:0], {"R1 sum ", tag}, 64'(s32), 64'(e[31:0]));
    chk(co32 == e[32], {"R2 carry ", tag}, 64'(co32), 64'(e[32]));
  endtask

  task automatic exact32(input string tag, input logic [31:0] es, input logic ec);
    chk(s32 == es, {tag, " sum"}, 64'(s32), 64'(es));
    chk(co32 == ec, {tag, " carry"}, 64'(co32), 64'(ec));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    exact32("R6 reset zero", 32'h0, 1'b0);

    // R1 R2: exhaustive sweep on the 4-bit instance
    for (int ai = 0; ai < 16; ai++) begin
      for (int bi = 0; bi < 16; bi++) begin
        for (int ci = 0; ci < 2; ci++) begin
          logic [4:0] e;
          @(posedge clk);
          a4 = 4'(ai); b4 = 4'(bi); c4 = 1'(ci);
          @(negedge clk);
          e = 5'(ai + bi + ci);
          chk(s4 == e[3:0], "R1 w4 sum", 64'(s4), 64'(e[3:0]));
          chk(co4 == e[4], "R2 w4 carry", 64'(co4), 64'(e[4]));
        end
      end
    end

    // R1 R2: random vectors on the 32-bit instance
    for (int k = 0; k < 1000; k++) begin
      apply32($urandom, $urandom, 1'($urandom));
      arith32("random");
    end

    apply32(32'h8000_0000, 32'h8000_0000, 1'b0);
    exact32("R3 top generate", 32'h0, 1'b1);
    apply32(32'hC3A5_0001, 32'h8F00_FFFF, 1'b1);
    chk(co32 == 1'b1, "R3 top generate mixed", 64'(co32), 64'd1);

    apply32(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1);
    exact32("R4 top kill", 32'hFFFF_FFFF, 1'b0);
    apply32(32'h7FFF_FFFF, 32'h0000_0001, 1'b1);
    exact32("R4 top kill carry in", 32'h8000_0001, 1'b0);

    apply32(32'h5A5A_A5A5, 32'hA5A5_5A5A, 1'b0);
    exact32("R5 full propagate ci0", 32'hFFFF_FFFF, 1'b0);
    apply32(32'h5A5A_A5A5, 32'hA5A5_5A5A, 1'b1);
    exact32("R5 full propagate ci1", 32'h0, 1'b1);
    apply32(32'h0000_0000, 32'hFFFF_FFFF, 1'b1);
    exact32("R5 propagate chain", 32'h0, 1'b1);
    apply32(32'h0000_0001, 32'hFFFF_FFFF, 1'b0);
    exact32("R2 generate at bit0 chain", 32'h0, 1'b1);

    apply32(32'h0, 32'h0, 1'b1);
    exact32("R6 zero operands ci1", 32'h1, 1'b0);
    apply32(32'h0, 32'h0, 1'b0);
    exact32("R6 zero operands ci0", 32'h0, 1'b0);

    apply32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    exact32("R7 all ones ci0", 32'hFFFF_FFFE, 1'b1);
    apply32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    exact32("R7 all ones ci1", 32'hFFFF_FFFF, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule